// File: doc/BRIEF.md
# Clock Stop Power Controller

This controller puts a small microcontroller core into its deepest low-power state and brings it back out. The instruction pipeline raises a stop request carrying a 4-bit operand. The request is honoured only when the operand is all zeros and the chip-enable pin is low. When it is honoured, the block drops the oscillator enable, the CPU and peripheral clock enables, and the power-failure detector enable. It keeps them low until a wake-up event arrives.

There are two wake-up events. The first is a rising edge on chip enable, which is taken through a synchronizer. The second is a power-on-reset indication from the supply monitor. Each wake-up fires a one-cycle reset request of the matching kind and records the cause in a register that software can read after the restart. If both events arrive in the same cycle, the power-on reset wins.

The block runs from a free-running always-on sampling clock, because the main clock is stopped. The analog oscillator, voltage sensing and reset sequencing sit outside the block.

Top module: `clkstop_ctrl`

## Requirements
- R1: A stop request is accepted only when `stop_arg` equals 4'b0000. Any other operand leaves the block running.
- R2: A stop request is ignored, with no change at any output, while the synchronized chip-enable level is high.
- R3: An accepted stop request drives `stop_active` high and `osc_en` low after the clock edge that samples it.
- R4: `cpu_clk_en` and `per_clk_en` are low for the whole time `stop_active` is high, and high while it is low.
- R5: A chip-enable rise while stopped leaves the stop state and gives a one-cycle `ce_rst_pulse`. If `chip_en` rises before edge k, `stop_active` falls and the pulse shows after edge k+2, because of the two-flop synchronizer and the edge register.
- R6: A `por_ind` sampled high while stopped leaves the stop state at that same edge and gives a one-cycle `por_rst_pulse`.
- R7: When `por_ind` and a chip-enable rise coincide while stopped, only `por_rst_pulse` fires.
- R8: `pfd_en` is low throughout the stop state and high again after any exit, including an exit by power-on reset.
- R9: `wake_cause` reads 2'b00 after reset, 2'b01 after a chip-enable wake-up and 2'b10 after a power-on wake-up. It holds its value until the next wake-up.
- R10: After `rst_n` is asserted, `stop_active` is 0, every enable is 1, both pulses are 0 and `wake_cause` is 2'b00.
- R11: Two inputs have no effect outside their own state:
  - a stop request while already stopped does nothing;
  - `por_ind` while running produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aon_clk | input | 1 | Free-running always-on sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Asynchronous chip-enable pin level |
| stop_req | input | 1 | Stop request strobe from the pipeline |
| stop_arg | input | 4 | Operand of the stop request |
| por_ind | input | 1 | Power-on-reset indication from the supply monitor |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pfd_en | output | 1 | Power-failure detector enable |
| stop_active | output | 1 | High exactly while in the clock stop state |
| ce_rst_pulse | output | 1 | One-cycle chip-enable reset request |
| por_rst_pulse | output | 1 | One-cycle power-on reset request |
| wake_cause | output | 2 | Cause of the last wake-up: 00 none, 01 chip enable, 10 power-on |

## Verification
The checker watches several rules on every cycle:
- entry into stop happens only after an accepted request taken with chip enable synchronized low;
- every enable is off while stopped;
- each exit produces exactly one single-cycle pulse, with power-on priority;
- no pulse appears while running.

The bench scenarios show the rest:
- the exact cycle count from a chip-enable pin edge to the wake-up pulse through the synchronizer;
- that the recorded cause persists across later idle cycles;
- that a request with a wrong operand or chip enable high leaves every port unchanged.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        WAKE_NONE = 2'b00,
        WAKE_CE   = 2'b01,
        WAKE_POR  = 2'b10
    } wake_e;

    typedef struct packed {
        state_e state;
        logic   run_en;
        logic   pfd_en;
        logic   ce_pulse;
        logic   por_pulse;
        wake_e  cause;
    } ctl_t;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic aon_clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl_out,
    output logic rise_out
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] stg;
        logic          prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.stg  = {s_q.stg[LAST-1:0], async_in};
        s_d.prev = s_q.stg[LAST];
    end

    always_ff @(posedge aon_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl_out  = s_q.stg[LAST];
    assign rise_out = s_q.stg[LAST] & ~s_q.prev;
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
    import clkstop_pkg::*;
#(
    parameter int              OP_W      = 4,
    parameter logic [OP_W-1:0] STOP_CODE = '0
) (
    input  logic            aon_clk,
    input  logic            rst_n,
    input  logic            stop_req,
    input  logic [OP_W-1:0] stop_arg,
    input  logic            ce_lvl,
    input  logic            ce_rise,
    input  logic            por_ind,
    output ctl_t            ctl_q
);
    localparam ctl_t CTL_RST = '{state: ST_RUN, run_en: 1'b1, pfd_en: 1'b1,
                                 ce_pulse: 1'b0, por_pulse: 1'b0, cause: WAKE_NONE};

    ctl_t ctl_d;
    logic accept;

    assign accept = stop_req && (stop_arg == STOP_CODE) && !ce_lvl;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.ce_pulse  = 1'b0;
        ctl_d.por_pulse = 1'b0;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (accept) begin
                    ctl_d.state  = ST_STOP;
                    ctl_d.run_en = 1'b0;
                    ctl_d.pfd_en = 1'b0;
                end
            end
            ST_STOP: begin
                if (por_ind) begin
                    ctl_d.state     = ST_RUN;
                    ctl_d.run_en    = 1'b1;
                    ctl_d.pfd_en    = 1'b1;
                    ctl_d.por_pulse = 1'b1;
                    ctl_d.cause     = WAKE_POR;
                end else if (ce_rise) begin
                    ctl_d.state    = ST_RUN;
                    ctl_d.run_en   = 1'b1;
                    ctl_d.pfd_en   = 1'b1;
                    ctl_d.ce_pulse = 1'b1;
                    ctl_d.cause    = WAKE_CE;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge aon_clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OP_W        = 4
) (
    input  logic            aon_clk,
    input  logic            rst_n,
    input  logic            chip_en,
    input  logic            stop_req,
    input  logic [OP_W-1:0] stop_arg,
    input  logic            por_ind,
    output logic            osc_en,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            pfd_en,
    output logic            stop_active,
    output logic            ce_rst_pulse,
    output logic            por_rst_pulse,
    output logic [1:0]      wake_cause
);
    logic ce_s;
    logic ce_rise;
    ctl_t ctl_q;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .aon_clk  (aon_clk),
        .rst_n    (rst_n),
        .async_in (chip_en),
        .lvl_out  (ce_s),
        .rise_out (ce_rise)
    );

    clkstop_fsm #(.OP_W(OP_W), .STOP_CODE('0)) u_fsm (
        .aon_clk  (aon_clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .stop_arg (stop_arg),
        .ce_lvl   (ce_s),
        .ce_rise  (ce_rise),
        .por_ind  (por_ind),
        .ctl_q    (ctl_q)
    );

    assign stop_active   = (ctl_q.state == ST_STOP);
    assign osc_en        = ctl_q.run_en;
    assign cpu_clk_en    = ctl_q.run_en;
    assign per_clk_en    = ctl_q.run_en;
    assign pfd_en        = ctl_q.pfd_en;
    assign ce_rst_pulse  = ctl_q.ce_pulse;
    assign por_rst_pulse = ctl_q.por_pulse;
    assign wake_cause    = ctl_q.cause;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
    parameter int OP_W = 4
) (
    input logic            aon_clk,
    input logic            rst_n,
    input logic            ce_s,
    input logic            stop_req,
    input logic [OP_W-1:0] stop_arg,
    input logic            por_ind,
    input logic            osc_en,
    input logic            cpu_clk_en,
    input logic            per_clk_en,
    input logic            pfd_en,
    input logic            stop_active,
    input logic            ce_rst_pulse,
    input logic            por_rst_pulse,
    input logic [1:0]      wake_cause
);
    // R1 R2 R3
    stop_entry_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        $rose(stop_active) |-> $past(stop_req && stop_arg == '0 && !ce_s));

    // R3 R4
    clocks_gated_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        stop_active |-> (!osc_en && !cpu_clk_en && !per_clk_en));

    // R8
    pfd_masked_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        stop_active |-> !pfd_en);

    // R5 R6
    exit_pulse_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        $fell(stop_active) |-> (ce_rst_pulse ^ por_rst_pulse));

    // R5
    ce_single_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        ce_rst_pulse |=> !ce_rst_pulse);

    // R6
    por_single_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        por_rst_pulse |=> !por_rst_pulse);

    // R7
    por_priority_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        (stop_active && por_ind) |=> (por_rst_pulse && !ce_rst_pulse));

    // R11
    idle_no_pulse_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        !stop_active |=> (!ce_rst_pulse && !por_rst_pulse));

    // R9
    cause_ce_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        ce_rst_pulse |-> (wake_cause == 2'b01));

    // R9
    cause_por_chk: assert property (@(posedge aon_clk) disable iff (!rst_n)
        por_rst_pulse |-> (wake_cause == 2'b10));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.OP_W(OP_W)) u_chk (
    .aon_clk       (aon_clk),
    .rst_n         (rst_n),
    .ce_s          (ce_s),
    .stop_req      (stop_req),
    .stop_arg      (stop_arg),
    .por_ind       (por_ind),
    .osc_en        (osc_en),
    .cpu_clk_en    (cpu_clk_en),
    .per_clk_en    (per_clk_en),
    .pfd_en        (pfd_en),
    .stop_active   (stop_active),
    .ce_rst_pulse  (ce_rst_pulse),
    .por_rst_pulse (por_rst_pulse),
    .wake_cause    (wake_cause)
);

// File: tb/clkstop_ctrl_tb.sv
module clkstop_ctrl_tb;
    logic       aon_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       chip_en = 1'b0;
    logic       stop_req = 1'b0;
    logic [3:0] stop_arg = 4'h0;
    logic       por_ind = 1'b0;
    logic       osc_en, cpu_clk_en, per_clk_en, pfd_en, stop_active;
    logic       ce_rst_pulse, por_rst_pulse;
    logic [1:0] wake_cause;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 aon_clk = ~aon_clk;

    clkstop_ctrl u_dut (
        .aon_clk(aon_clk), .rst_n(rst_n), .chip_en(chip_en),
        .stop_req(stop_req), .stop_arg(stop_arg), .por_ind(por_ind),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .pfd_en(pfd_en), .stop_active(stop_active),
        .ce_rst_pulse(ce_rst_pulse), .por_rst_pulse(por_rst_pulse),
        .wake_cause(wake_cause)
    );

    typedef struct packed {
        logic [1:0] ticks;
        logic       ce;
        logic       req;
        logic [3:0] arg;
        logic       por;
        logic       stop;
        logic [1:0] cause;
        logic       cep;
        logic       porp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b1, 4'h5, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R1 wrong operand
        '{2'd1, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R3 accepted
        '{2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R4 hold
        '{2'd2, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0}, // R5 sync delay
        '{2'd1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0}, // R5 exit
        '{2'd1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0}, // R5 single pulse
        '{2'd1, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0}, // R2 ce high no-op
        '{2'd2, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0}, // R9 cause holds
        '{2'd1, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0}, // R3 enter again
        '{2'd1, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0}, // R11 req while stopped
        '{2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1}, // R6 por exit
        '{2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0}, // R8 pfd back
        '{2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0}  // R11 por while running
    };

    task automatic tick();
        @(posedge aon_clk);
        #5;
    endtask

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic stp, input logic [1:0] cause,
                           input logic cep, input logic porp);
        chk({tag, " stop_active"}, {3'b0, stop_active}, {3'b0, stp});
        chk({tag, " R3 osc_en"}, {3'b0, osc_en}, {3'b0, ~stp});
        chk({tag, " R4 cpu_clk_en"}, {3'b0, cpu_clk_en}, {3'b0, ~stp});
        chk({tag, " R4 per_clk_en"}, {3'b0, per_clk_en}, {3'b0, ~stp});
        chk({tag, " R8 pfd_en"}, {3'b0, pfd_en}, {3'b0, ~stp});
        chk({tag, " R9 wake_cause"}, {2'b0, wake_cause}, {2'b0, cause});
        chk({tag, " ce_rst_pulse"}, {3'b0, ce_rst_pulse}, {3'b0, cep});
        chk({tag, " por_rst_pulse"}, {3'b0, por_rst_pulse}, {3'b0, porp});
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R10 reset state
        chk_all("R10 in reset", 1'b0, 2'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (3) tick();
        chk_all("R10 after reset", 1'b0, 2'd0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            chip_en  = VECS[i].ce;
            stop_req = VECS[i].req;
            stop_arg = VECS[i].arg;
            por_ind  = VECS[i].por;
            for (int t = 0; t < int'(VECS[i].ticks); t++) tick();
            chk_all($sformatf("vec%0d", i), VECS[i].stop, VECS[i].cause,
                    VECS[i].cep, VECS[i].porp);
        end
        stop_req = 1'b0;
        por_ind  = 1'b0;

        // R7: por and chip-enable rise in the same cycle
        chip_en = 1'b0;
        repeat (2) tick();
        stop_req = 1'b1; stop_arg = 4'h0;
        tick();
        stop_req = 1'b0;
        chk_all("R7 entered", 1'b1, 2'd2, 1'b0, 1'b0);
        chip_en = 1'b1;
        repeat (2) tick();
        chk_all("R7 pending", 1'b1, 2'd2, 1'b0, 1'b0);
        por_ind = 1'b1;
        tick();
        chk_all("R7 coincide", 1'b0, 2'd2, 1'b0, 1'b1);
        por_ind = 1'b0;
        tick();
        chk_all("R7 after", 1'b0, 2'd2, 1'b0, 1'b0);

        // R1: all-ones operand rejected
        chip_en = 1'b0;
        repeat (2) tick();
        stop_req = 1'b1; stop_arg = 4'hF;
        tick();
        stop_req = 1'b0;
        chk_all("R1 operand F", 1'b0, 2'd2, 1'b0, 1'b0);

        // R10: reset while stopped
        stop_req = 1'b1; stop_arg = 4'h0;
        tick();
        stop_req = 1'b0;
        chk_all("R10 stopped", 1'b1, 2'd2, 1'b0, 1'b0);
        rst_n = 1'b0;
        tick();
        chk_all("R10 reset mid-stop", 1'b0, 2'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule